// File: doc/BRIEF.md
# SDRAM Burst Access Scheduler

This block sits in a memory controller between the request intake and the command sequencer. It holds pending reads and writes in one queue per bank. Each cycle it offers exactly one of them on the command side. Requests arrive on a valid/ready port that carries the access type, bank, row, column and tag.

The block keeps its own record of the open row of every bank. It uses that record to cluster accesses that fall on the same open row into back-to-back bursts, which lowers the row conflict rate. Within a burst, reads go first and writes that hit the same row follow at the tail. A read may overtake older writes, but only a limited number of times before the oldest write of the bank is forced out. A read never passes an older write to the same row and column. When the current bank has no more open-row hits, the scheduler moves round-robin to the next bank that holds work, so that traffic is spread across banks.

SDRAM timing, refresh, the data path and address mapping are handled elsewhere.

Top module: `burst_sched`

## Requirements
- R1: After reset `cmd_valid_o` is 0, `req_ready_o` is 1 for every bank, and every bank's row is closed, so the first command to any bank reports `cmd_row_hit_o` = 0.
- R2: Within one bank, pending requests to the currently open row are issued before any request to another row of that bank.
- R3: `cmd_row_hit_o` is 1 exactly when the offered command's row equals the open row recorded for its bank. Each issued command (`cmd_valid_o` and `cmd_ready_i` both 1) makes its row the open row of its bank.
- R4: Among the candidates of a bank, the oldest read is chosen ahead of older writes while the bypass count is below `PREEMPT_MAX`. Issuing a read while an older write waits in its bank raises the bypass count by one.
- R5: A write to the open row is issued after the reads to that row that are eligible, at the tail of the burst, and issuing a write clears the bypass count.
- R6: Once `PREEMPT_MAX` bypassing reads have issued with no write between them, the next command from a bank holding writes is that bank's oldest write.
- R7: A read is never issued while an older write to the same bank, row and column is pending.
- R8: The bank of the previous command keeps the command slot while it holds open-row hits. Otherwise the slot goes to the first bank holding requests, searching from the previous bank plus one with wrap-around (bank numbers 0 to `NUM_BANKS`-1).
- R9: `req_ready_o` is 0 exactly when the queue of the bank on `req_bank_i` holds `QUEUE_DEPTH` entries.
- R10: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the command stays valid and all of its fields hold their values, even if new requests arrive.
- R11: `cmd_valid_o` is 1 exactly when at least one request is pending in any bank queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Target bank queue can accept |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_tag_i | input | TAG_W | Request identifier |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_write_o | output | 1 | 1 = write, 0 = read |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| cmd_col_o | output | COL_W | Command column |
| cmd_tag_o | output | TAG_W | Tag of the issued request |
| cmd_row_hit_o | output | 1 | Command targets the bank's open row |

## Verification
The checker assumes that requests are offered only while `req_ready_o` is high, because its shadow queue occupancy counts handshakes only. It also assumes that the command consumer keeps `cmd_ready_i` at a value that does not change between edges. The bench changes every input on the falling clock edge. It offers each request for a single accepted cycle, and it holds `cmd_ready_i` low while it loads a scenario, so that the locking of the offered command is exercised. A first request parked in a bank with an open-row hit is drained before the queued pattern, so that the ordering under test is set by the queue contents and not by the arrival order.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/bs_bank_q.sv
module bs_bank_q import bs_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  op_e              push_op_i,
  input  logic [ROW_W-1:0] push_row_i,
  input  logic [COL_W-1:0] push_col_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             pop_i,
  input  logic             open_v_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             force_wr_i,
  input  logic             hold_i,
  input  logic [IDX_W-1:0] hold_idx_i,
  output logic             full_o,
  output logic             any_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] pick_idx_o,
  output op_e              pick_op_o,
  output logic [ROW_W-1:0] pick_row_o,
  output logic [COL_W-1:0] pick_col_o,
  output logic [TAG_W-1:0] pick_tag_o,
  output logic             pick_byp_o
);
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q  [DEPTH];
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [COL_W-1:0] col_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  logic [DEPTH-1:0] vld, blk, elig, hit, wr_m, cand, rd_c, sel_m;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] wpos;

  // index 0 holds the oldest entry; pushes append, pops compact
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld[i]  = CNT_W'(i) < cnt_q;
      wr_m[i] = vld[i] && (op_q[i] == OP_WR);
    end
    blk = '0;
    for (int i = 1; i < DEPTH; i++)
      for (int j = 0; j < i; j++)
        if (wr_m[j] && vld[i] && op_q[i] == OP_RD &&
            row_q[j] == row_q[i] && col_q[j] == col_q[i])
          blk[i] = 1'b1;
    elig = vld & ~blk;
    for (int i = 0; i < DEPTH; i++)
      hit[i] = elig[i] && open_v_i && (row_q[i] == open_row_i);
    cand = (|hit) ? hit : elig;
    for (int i = 0; i < DEPTH; i++)
      rd_c[i] = cand[i] && (op_q[i] == OP_RD);
    if (force_wr_i && |wr_m) sel_m = wr_m;
    else if (|rd_c)          sel_m = rd_c;
    else                     sel_m = cand;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (sel_m[i]) idx = IDX_W'(i);
    if (hold_i) idx = hold_idx_i;
    pick_byp_o = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (wr_m[j] && IDX_W'(j) < idx) pick_byp_o = 1'b1;
  end

  assign pick_idx_o = idx;
  assign pick_op_o  = op_q[idx];
  assign pick_row_o = row_q[idx];
  assign pick_col_o = col_q[idx];
  assign pick_tag_o = tag_q[idx];
  assign full_o     = cnt_q == CNT_W'(DEPTH);
  assign any_o      = cnt_q != '0;
  assign hit_o      = |hit;
  assign wpos       = cnt_q - CNT_W'(pop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH - 1; i++)
      if (pop_i && IDX_W'(i) >= idx) begin
        op_q[i]  <= op_q[i+1];
        row_q[i] <= row_q[i+1];
        col_q[i] <= col_q[i+1];
        tag_q[i] <= tag_q[i+1];
      end
    if (push_i) begin
      op_q[IDX_W'(wpos)]  <= push_op_i;
      row_q[IDX_W'(wpos)] <= push_row_i;
      col_q[IDX_W'(wpos)] <= push_col_i;
      tag_q[IDX_W'(wpos)] <= push_tag_i;
    end
  end
endmodule

// File: rtl/bs_bank_rr.sv
module bs_bank_rr #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [BANK_W-1:0]    cur_i,
  input  logic [NUM_BANKS-1:0] hit_i,
  input  logic [NUM_BANKS-1:0] any_i,
  output logic [BANK_W-1:0]    sel_o,
  output logic                 sel_v_o
);
  logic [BANK_W-1:0] b;

  always_comb begin
    sel_o   = cur_i;
    sel_v_o = 1'b0;
    b       = cur_i;
    if (hit_i[cur_i]) begin
      sel_v_o = 1'b1;
    end else begin
      // scan farthest first so the nearest following bank wins
      for (int k = NUM_BANKS; k >= 1; k--) begin
        b = cur_i + BANK_W'(k);
        if (any_i[b]) begin
          sel_o   = b;
          sel_v_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/burst_sched.sv
module burst_sched import bs_pkg::*; #(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 8,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 10,
  parameter int TAG_W       = 4,
  parameter int PREEMPT_MAX = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(QUEUE_DEPTH),
  localparam int PCNT_W = $clog2(PREEMPT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_write_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic [TAG_W-1:0]  cmd_tag_o,
  output logic              cmd_row_hit_o
);
  logic [NUM_BANKS-1:0] q_full, q_any, q_hit, q_byp;
  logic [IDX_W-1:0]     q_idx [NUM_BANKS];
  op_e                  q_op  [NUM_BANKS];
  logic [ROW_W-1:0]     q_row [NUM_BANKS];
  logic [COL_W-1:0]     q_col [NUM_BANKS];
  logic [TAG_W-1:0]     q_tag [NUM_BANKS];

  logic [NUM_BANKS-1:0] open_v_q;
  logic [ROW_W-1:0]     open_row_q [NUM_BANKS];
  logic [BANK_W-1:0]    cur_q, lock_bank_q, rr_sel, sel;
  logic [IDX_W-1:0]     lock_idx_q;
  logic                 lock_q, rr_v, fire, in_fire;
  logic [PCNT_W-1:0]    pcnt_q;
  logic                 force_wr;

  assign req_ready_o = !q_full[req_bank_i];
  assign in_fire     = req_valid_i && req_ready_o;
  assign force_wr    = pcnt_q >= PCNT_W'(PREEMPT_MAX);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bs_bank_q #(
      .DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W)
    ) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (in_fire && req_bank_i == BANK_W'(g)),
      .push_op_i  (req_write_i ? OP_WR : OP_RD),
      .push_row_i (req_row_i),
      .push_col_i (req_col_i),
      .push_tag_i (req_tag_i),
      .pop_i      (fire && sel == BANK_W'(g)),
      .open_v_i   (open_v_q[g]),
      .open_row_i (open_row_q[g]),
      .force_wr_i (force_wr),
      .hold_i     (lock_q && lock_bank_q == BANK_W'(g)),
      .hold_idx_i (lock_idx_q),
      .full_o     (q_full[g]),
      .any_o      (q_any[g]),
      .hit_o      (q_hit[g]),
      .pick_idx_o (q_idx[g]),
      .pick_op_o  (q_op[g]),
      .pick_row_o (q_row[g]),
      .pick_col_o (q_col[g]),
      .pick_tag_o (q_tag[g]),
      .pick_byp_o (q_byp[g])
    );
  end

  bs_bank_rr #(.NUM_BANKS(NUM_BANKS)) u_rr (
    .cur_i   (cur_q),
    .hit_i   (q_hit),
    .any_i   (q_any),
    .sel_o   (rr_sel),
    .sel_v_o (rr_v)
  );

  assign sel           = lock_q ? lock_bank_q : rr_sel;
  assign cmd_valid_o   = lock_q || rr_v;
  assign fire          = cmd_valid_o && cmd_ready_i;
  assign cmd_write_o   = q_op[sel] == OP_WR;
  assign cmd_bank_o    = sel;
  assign cmd_row_o     = q_row[sel];
  assign cmd_col_o     = q_col[sel];
  assign cmd_tag_o     = q_tag[sel];
  assign cmd_row_hit_o = open_v_q[sel] && (open_row_q[sel] == q_row[sel]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_v_q    <= '0;
      for (int b = 0; b < NUM_BANKS; b++) open_row_q[b] <= '0;
      cur_q       <= '0;
      lock_q      <= 1'b0;
      lock_bank_q <= '0;
      lock_idx_q  <= '0;
      pcnt_q      <= '0;
    end else begin
      if (fire) begin
        lock_q          <= 1'b0;
        cur_q           <= sel;
        open_v_q[sel]   <= 1'b1;
        open_row_q[sel] <= q_row[sel];
        if (q_op[sel] == OP_WR)
          pcnt_q <= '0;
        else if (q_byp[sel] && !force_wr)
          pcnt_q <= pcnt_q + 1'b1;
      end else if (cmd_valid_o && !lock_q) begin
        // freeze the offered command until it is taken
        lock_q      <= 1'b1;
        lock_bank_q <= sel;
        lock_idx_q  <= q_idx[sel];
      end
    end
  end
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 8,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 10,
  parameter int TAG_W       = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BANK_W-1:0] req_bank_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic              cmd_write_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic [COL_W-1:0]  cmd_col_o,
  input logic [TAG_W-1:0]  cmd_tag_o,
  input logic              cmd_row_hit_o
);
  logic [CNT_W-1:0]     occ [NUM_BANKS];
  logic [NUM_BANKS-1:0] m_open_v;
  logic [ROW_W-1:0]     m_open_row [NUM_BANKS];
  logic                 m_any;

  always_comb begin
    m_any = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) m_any = m_any || (occ[b] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_open_v <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        occ[b]        <= '0;
        m_open_row[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++)
        occ[b] <= occ[b]
                + CNT_W'(req_valid_i && req_ready_o && req_bank_i == BANK_W'(b))
                - CNT_W'(cmd_valid_o && cmd_ready_i && cmd_bank_o == BANK_W'(b));
      if (cmd_valid_o && cmd_ready_i) begin
        m_open_v[cmd_bank_o]   <= 1'b1;
        m_open_row[cmd_bank_o] <= cmd_row_o;
      end
    end
  end

  assert_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == (occ[req_bank_i] != CNT_W'(QUEUE_DEPTH)));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (occ[req_bank_i] < CNT_W'(QUEUE_DEPTH)));

  assert_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == m_any);

  assert_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_tag_o) &&
      $stable(cmd_bank_o) && $stable(cmd_row_o) && $stable(cmd_col_o) &&
      $stable(cmd_write_o)));

  assert_row_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_row_hit_o ==
      (m_open_v[cmd_bank_o] && m_open_row[cmd_bank_o] == cmd_row_o)));
endmodule

bind burst_sched bs_checker #(
  .NUM_BANKS(NUM_BANKS), .QUEUE_DEPTH(QUEUE_DEPTH),
  .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/burst_sched_tb.sv
`timescale 1ns/1ps
module burst_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  req_tag = '0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_write, cmd_hit;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [9:0]  cmd_col;
  logic [3:0]  cmd_tag;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_tag_i(req_tag),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
    .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .cmd_tag_o(cmd_tag), .cmd_row_hit_o(cmd_hit)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic push(input bit w, input int bank, input int row, input int col, input int tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = 2'(bank);
    req_row = 13'(row); req_col = 10'(col); req_tag = 4'(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // expects the command, then accepts it for one cycle
  task automatic take(input string rq, input int tag, input bit w, input int bank, input bit hit);
    @(negedge clk); #1;
    check(cmd_valid && cmd_tag == 4'(tag), rq, int'(cmd_tag), tag);
    check({cmd_write, cmd_bank, cmd_hit} == {w, 2'(bank), hit}, rq,
          int'({cmd_write, cmd_bank, cmd_hit}), int'({w, 2'(bank), hit}));
    cmd_ready = 1'b1;
    @(posedge clk); #1;
    cmd_ready = 1'b0;
  endtask

  task automatic idle_check(input string rq);
    @(negedge clk); #1;
    check(!cmd_valid, rq, int'(cmd_valid), 0);
  endtask

  task automatic t_reset;
    #1;
    check(!cmd_valid, "R1 valid after reset", int'(cmd_valid), 0);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_burst;
    push(0, 0, 5, 1, 1);
    push(0, 0, 7, 2, 2);
    push(0, 0, 5, 3, 3);
    take("R1 first cmd row closed", 1, 0, 0, 0);
    take("R2 same row joins burst", 3, 0, 0, 1);
    take("R3 other row after burst", 2, 0, 0, 0);
    idle_check("R11 idle after burst");
  endtask

  task automatic t_piggy;
    push(0, 0, 7, 0, 15);
    push(1, 1, 2, 0, 4);
    push(0, 1, 2, 1, 5);
    push(0, 1, 2, 2, 6);
    take("R8 parked request", 15, 0, 0, 1);
    take("R4 read passes older write", 5, 0, 1, 0);
    take("R4 second read in burst", 6, 0, 1, 1);
    take("R5 write at burst tail", 4, 1, 1, 1);
    idle_check("R11 idle after piggyback");
  endtask

  task automatic t_thresh;
    push(0, 0, 7, 0, 15);
    push(1, 2, 1, 0, 7);
    for (int c = 1; c <= 4; c++) push(0, 2, 1, c, 7 + c);
    take("R8 parked request", 15, 0, 0, 1);
    take("R4 bypass 1", 8, 0, 2, 0);
    take("R4 bypass 2", 9, 0, 2, 1);
    take("R4 bypass 3", 10, 0, 2, 1);
    take("R6 write forced at limit", 7, 1, 2, 1);
    take("R5 count cleared by write", 11, 0, 2, 1);
    idle_check("R11 idle after threshold");
  endtask

  task automatic t_order;
    push(0, 0, 7, 0, 15);
    push(1, 3, 4, 9, 12);
    push(0, 3, 4, 9, 13);
    push(0, 3, 4, 8, 14);
    take("R8 parked request", 15, 0, 0, 1);
    take("R7 unrelated read may pass", 14, 0, 3, 0);
    take("R7 same column write first", 12, 1, 3, 1);
    take("R7 dependent read last", 13, 0, 3, 1);
    idle_check("R11 idle after ordering");
  endtask

  task automatic t_rotate;
    push(0, 0, 7, 5, 1);
    push(0, 0, 7, 6, 2);
    push(0, 1, 2, 3, 3);
    push(0, 2, 9, 0, 4);
    take("R8 bank0 opens", 1, 0, 0, 1);
    take("R8 bank0 keeps slot on hit", 2, 0, 0, 1);
    take("R8 next bank1", 3, 0, 1, 1);
    take("R3 bank2 row change", 4, 0, 2, 0);
    push(0, 2, 9, 1, 15);
    push(0, 1, 2, 4, 5);
    push(0, 3, 4, 0, 6);
    take("R8 parked request", 15, 0, 2, 1);
    take("R8 wrap search starts at bank3", 6, 0, 3, 1);
    take("R8 then bank1", 5, 0, 1, 1);
    idle_check("R11 idle after rotation");
  endtask

  task automatic t_full;
    for (int c = 0; c < 8; c++) push(0, 0, 7, c, c);
    @(negedge clk); req_bank = 2'd0; #1;
    check(!req_ready, "R9 full bank not ready", int'(req_ready), 0);
    req_bank = 2'd1; #1;
    check(req_ready, "R9 other bank ready", int'(req_ready), 1);
    push(0, 1, 2, 7, 8);
    @(negedge clk); #1;
    check(cmd_valid && cmd_tag == 4'd0, "R10 held under stall", int'(cmd_tag), 0);
    for (int c = 0; c < 8; c++) take("R2 drain full bank", c, 0, 0, 1);
    take("R8 move to bank1", 8, 0, 1, 1);
    idle_check("R11 idle after drain");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_burst();
    t_piggy();
    t_thresh();
    t_order();
    t_rotate();
    t_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule